// File: doc/BRIEF.md
# Bit-plane coder sequencing controller

This block is the top-level sequencer of a per-code-block bit-plane encoder. It walks the encoder's sub-units through the work of each plane by a strict enable/finish handshake. It raises one stage enable and holds it until that unit reports completion. Only then does it move on. Each plane starts with a preprocessing phase. A layer stage loads the plane's magnitude bits, and a buffer-fill stage initialises the state buffers and clears the visited flags. A pattern-generation phase follows and issues the coding passes: significance propagation, then magnitude refinement, then cleanup.

Software or an upstream unit pulses `start` with the number of planes to code. The controller counts planes down from the most significant one. The most significant plane runs the cleanup pass only. Every pass covers the block one stripe at a time. The controller exposes a stripe index and advances it on each finish handshake of the pass unit. After the cleanup pass of plane 0 it pulses `done` and returns to idle.

Top module: `bpc_sequencer`

## Requirements
- R1: A `start` pulse in idle with a nonzero `num_planes` makes the block busy. In the next cycle the layer stage is enabled and `plane_idx` equals `num_planes`-1. A `start` with `num_planes` of zero is ignored, and the block stays idle with all enables low.
- R2: `stage_en` has at most one bit set, and a bit is set exactly while the block is busy. Bit 0 is layer, bit 1 is fill, bit 2 is significance, bit 3 is refinement and bit 4 is cleanup. While the enabled stage's finish bit is low, the enable, `plane_idx` and `stripe_idx` hold. Finish bits of stages that are not enabled have no effect.
- R3: Within a plane, the stages run in order: layer, fill, then the passes. Significance propagation is followed by refinement, and refinement is followed by cleanup.
- R4: On the first (most significant) plane, fill is followed directly by cleanup. Significance and refinement are skipped.
- R5: Each pass keeps its enable for STRIPES finish handshakes. `stripe_idx` starts at 0 and steps by one after each of these handshakes, and it is back at 0 when the next stage begins. The layer and fill stages each take a single handshake, with `stripe_idx` at 0.
- R6: After the last cleanup handshake of a plane other than plane 0, `plane_idx` decreases by one and the layer stage is enabled again.
- R7: After the last cleanup handshake of plane 0, `done` is high for exactly one cycle and the block is idle.
- R8: A `start` pulse while busy is ignored. The stage, plane and stripe are unchanged.
- R9: A synchronous reset, including one applied in the middle of a run, returns the block to idle. All enables and `done` go low, and `plane_idx` and `stripe_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin coding a block (accepted only when idle) |
| num_planes | input | PLANE_W | Number of bit planes to code, sampled with `start` |
| stage_fin | input | 5 | Per-stage completion strobes from the sub-units |
| stage_en | output | 5 | One-hot stage enables (layer, fill, sig, ref, cleanup) |
| plane_idx | output | PLANE_W | Index of the plane being coded |
| stripe_idx | output | $clog2(STRIPES) | Stripe within the block for the current pass |
| busy | output | 1 | A block is being coded |
| done | output | 1 | One-cycle pulse after the final cleanup pass |

## Verification
The bench builds the block with PLANE_W=3 and STRIPES=3. Three stripes exercise the first, middle and last stripe of every pass. A three-bit plane count reaches the largest run of seven planes as well as the single-plane case, where only cleanup runs. The bench answers every handshake with finish latencies from zero to three cycles. The zero-latency case tests back-to-back advancement. The longer latencies test that each enable holds while the controller waits.

// File: rtl/bpc_seq_pkg.sv
package bpc_seq_pkg;
    localparam int NUM_STAGES = 5;
    localparam int STG_LAYER  = 0;
    localparam int STG_FILL   = 1;
    localparam int STG_SIG    = 2;
    localparam int STG_REF    = 3;
    localparam int STG_CLN    = 4;

    // State code equals stage bit index + 1; idle is 0.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_LAYER = 3'd1,
        SQ_FILL  = 3'd2,
        SQ_SIG   = 3'd3,
        SQ_REF   = 3'd4,
        SQ_CLN   = 3'd5
    } seq_state_e;
endpackage

// File: rtl/bpc_stage_decode.sv
module bpc_stage_decode
    import bpc_seq_pkg::*;
(
    input  seq_state_e              state,
    output logic [NUM_STAGES-1:0]   en
);
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        localparam logic [2:0] CODE = 3'(g + 1);
        assign en[g] = (state == seq_state_e'(CODE));
    end
endmodule

// File: rtl/bpc_stripe_ctr.sv
module bpc_stripe_ctr #(
    parameter  int STRIPES = 8,
    localparam int IW      = (STRIPES > 1) ? $clog2(STRIPES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          last
);
    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign idx  = cnt_q;
    assign last = (cnt_q == IW'(STRIPES - 1));

    assert_stripe_range_R5: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < STRIPES);
    assert_no_step_past_end_R5: assert property (@(posedge clk) disable iff (rst)
        (step && last) |-> clr);
endmodule

// File: rtl/bpc_plane_ctr.sv
module bpc_plane_ctr #(
    parameter int PLANE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [PLANE_W-1:0] load_val,
    input  logic               dec,
    output logic [PLANE_W-1:0] idx,
    output logic               is_zero
);
    logic [PLANE_W-1:0] pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (load)     pl_d = load_val - 1'b1;
        else if (dec) pl_d = pl_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pl_q <= '0;
        else     pl_q <= pl_d;
    end

    assign idx     = pl_q;
    assign is_zero = (pl_q == '0);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        dec |-> !is_zero);
    assert_plane_step_R6: assert property (@(posedge clk) disable iff (rst)
        dec |=> (pl_q == $past(pl_q) - 1'b1));
endmodule

// File: rtl/bpc_sequencer.sv
module bpc_sequencer
    import bpc_seq_pkg::*;
#(
    parameter  int PLANE_W = 4,
    parameter  int STRIPES = 8,
    localparam int SW      = (STRIPES > 1) ? $clog2(STRIPES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [PLANE_W-1:0]    num_planes,
    input  logic [NUM_STAGES-1:0] stage_fin,
    output logic [NUM_STAGES-1:0] stage_en,
    output logic [PLANE_W-1:0]    plane_idx,
    output logic [SW-1:0]         stripe_idx,
    output logic                  busy,
    output logic                  done
);
    typedef struct packed {
        seq_state_e st;
        logic       first;
        logic       done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic pl_load, pl_dec, pl_zero;
    logic sc_clr, sc_step, sc_last;
    logic cur_fin;

    bpc_stage_decode u_decode (
        .state (ctl_q.st),
        .en    (stage_en)
    );

    bpc_plane_ctr #(.PLANE_W(PLANE_W)) u_plane (
        .clk      (clk),
        .rst      (rst),
        .load     (pl_load),
        .load_val (num_planes),
        .dec      (pl_dec),
        .idx      (plane_idx),
        .is_zero  (pl_zero)
    );

    bpc_stripe_ctr #(.STRIPES(STRIPES)) u_stripe (
        .clk  (clk),
        .rst  (rst),
        .clr  (sc_clr),
        .step (sc_step),
        .idx  (stripe_idx),
        .last (sc_last)
    );

    // Only the finish strobe of the enabled stage counts.
    assign cur_fin = |(stage_fin & stage_en);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        pl_load    = 1'b0;
        pl_dec     = 1'b0;
        sc_clr     = 1'b0;
        sc_step    = 1'b0;
        unique case (ctl_q.st)
            SQ_IDLE: begin
                if (start && num_planes != '0) begin
                    ctl_d.st    = SQ_LAYER;
                    ctl_d.first = 1'b1;
                    pl_load     = 1'b1;
                    sc_clr      = 1'b1;
                end
            end
            SQ_LAYER: begin
                if (cur_fin) ctl_d.st = SQ_FILL;
            end
            SQ_FILL: begin
                if (cur_fin) ctl_d.st = ctl_q.first ? SQ_CLN : SQ_SIG;
            end
            SQ_SIG: begin
                if (cur_fin) begin
                    if (sc_last) begin
                        ctl_d.st = SQ_REF;
                        sc_clr   = 1'b1;
                    end else begin
                        sc_step  = 1'b1;
                    end
                end
            end
            SQ_REF: begin
                if (cur_fin) begin
                    if (sc_last) begin
                        ctl_d.st = SQ_CLN;
                        sc_clr   = 1'b1;
                    end else begin
                        sc_step  = 1'b1;
                    end
                end
            end
            SQ_CLN: begin
                if (cur_fin) begin
                    if (sc_last) begin
                        sc_clr      = 1'b1;
                        ctl_d.first = 1'b0;
                        if (pl_zero) begin
                            ctl_d.st   = SQ_IDLE;
                            ctl_d.done = 1'b1;
                        end else begin
                            ctl_d.st   = SQ_LAYER;
                            pl_dec     = 1'b1;
                        end
                    end else begin
                        sc_step = 1'b1;
                    end
                end
            end
            default: ctl_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: SQ_IDLE, first: 1'b0, done: 1'b0};
        else     ctl_q <= ctl_d;
    end

    assign busy = (ctl_q.st != SQ_IDLE);
    assign done = ctl_q.done;

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_en) && ((|stage_en) == busy));
    assert_hold_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !(|(stage_fin & stage_en))) |=>
            ($stable(stage_en) && $stable(stripe_idx) && $stable(plane_idx)));
    assert_zero_count_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && num_planes == '0) |=> !busy);
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !cur_fin) |=> $stable(plane_idx));
    assert_fill_after_layer_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_en[STG_FILL]) |-> $past(stage_en[STG_LAYER]));
    assert_ref_after_sig_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_en[STG_REF]) |-> $past(stage_en[STG_SIG]));
    assert_first_skips_sig_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_en[STG_SIG]) |-> !ctl_q.first);
    assert_done_source_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(stage_en[STG_CLN]) && $past(plane_idx) == '0 && !busy));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/bpc_sequencer_tb.sv
module bpc_sequencer_tb;
    localparam int PW = 3;
    localparam int SN = 3;
    localparam int SWB = $clog2(SN);
    localparam int L_LAYER = 0, L_FILL = 1, L_SIG = 2, L_REF = 3, L_CLN = 4;

    // Each entry: {plane count[7:4], finish latency[3:0]}
    localparam logic [7:0] CASES [5] = '{8'h10, 8'h21, 8'h32, 8'h70, 8'h43};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [PW-1:0]  num_planes = '0;
    logic [4:0]     stage_fin = '0;
    logic [4:0]     stage_en;
    logic [PW-1:0]  plane_idx;
    logic [SWB-1:0] stripe_idx;
    logic           busy;
    logic           done;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    bpc_sequencer #(.PLANE_W(PW), .STRIPES(SN)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .num_planes (num_planes),
        .stage_fin  (stage_fin),
        .stage_en   (stage_en),
        .plane_idx  (plane_idx),
        .stripe_idx (stripe_idx),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One handshake: verify the enabled stage, optionally inject noise, then finish.
    task automatic do_event(input int stg, input int pl, input int sp, input int lat,
                            input int inject, input string req);
        logic [4:0] m = 5'(1 << stg);
        bit ok;
        ok = (stage_en == m) && (int'(plane_idx) == pl) && (int'(stripe_idx) == sp);
        if (!ok)
            $display("  at stage %0d plane %0d stripe %0d: en=%b plane=%0d stripe=%0d",
                     stg, pl, sp, stage_en, plane_idx, stripe_idx);
        if (inject == 1) begin
            start = 1'b1; num_planes = 3'd7;
            @(negedge clk);
            start = 1'b0;
            check(stage_en == m && int'(plane_idx) == pl, "R8", "plane after busy start",
                  int'(plane_idx), pl);
        end else if (inject == 2) begin
            stage_fin = ~m;
            @(negedge clk);
            stage_fin = '0;
            check(stage_en == m, "R2", "enable after foreign finish", int'(stage_en), int'(m));
        end
        repeat (lat) begin
            @(negedge clk);
            if (stage_en != m || int'(stripe_idx) != sp) ok = 1'b0;
        end
        check(ok, req, "stage enable", int'(stage_en), int'(m));
        stage_fin = m;
        @(negedge clk);
        stage_fin = '0;
    endtask

    task automatic run_block(input int n, input int lat, input int inject);
        start = 1'b1; num_planes = PW'(n);
        @(negedge clk);
        start = 1'b0;
        for (int p = n - 1; p >= 0; p--) begin
            do_event(L_LAYER, p, 0, lat, (p == n - 1) ? inject : 0, (p == n - 1) ? "R1" : "R6");
            do_event(L_FILL, p, 0, lat, 0, "R3");
            if (p != n - 1) begin
                for (int s = 0; s < SN; s++) do_event(L_SIG, p, s, lat, 0, "R5");
                for (int s = 0; s < SN; s++) do_event(L_REF, p, s, lat, 0, "R3");
            end
            for (int s = 0; s < SN; s++)
                do_event(L_CLN, p, s, lat, 0, (p == n - 1) ? "R4" : "R5");
        end
        check(done && !busy && stage_en == '0, "R7", "done pulse", int'(done), 1);
        @(negedge clk);
        check(!done && !busy, "R7", "done cleared", int'(done), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check(stage_en == '0 && !busy && !done && plane_idx == '0 && stripe_idx == '0,
              "R9", "reset state", int'(stage_en), 0);
        @(negedge clk);
        // R1: zero plane count is ignored
        start = 1'b1; num_planes = '0;
        @(negedge clk);
        start = 1'b0;
        check(!busy && stage_en == '0, "R1", "busy after zero-count start", int'(busy), 0);
        @(negedge clk);

        for (int i = 0; i < 5; i++)
            run_block(int'(CASES[i][7:4]), int'(CASES[i][3:0]), 0);

        run_block(3, 1, 1);   // R8 start while busy
        run_block(2, 0, 2);   // R2 foreign finish strobes

        // R9: reset in the middle of a significance pass
        start = 1'b1; num_planes = 3'd2;
        @(negedge clk);
        start = 1'b0;
        do_event(L_LAYER, 1, 0, 0, 0, "R1");
        do_event(L_FILL, 1, 0, 0, 0, "R3");
        for (int s = 0; s < SN; s++) do_event(L_CLN, 1, s, 0, 0, "R4");
        do_event(L_LAYER, 0, 0, 0, 0, "R6");
        do_event(L_FILL, 0, 0, 0, 0, "R3");
        do_event(L_SIG, 0, 0, 0, 0, "R5");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(stage_en == '0 && !busy && !done && plane_idx == '0 && stripe_idx == '0,
              "R9", "state after mid-run reset", int'(stage_en), 0);
        @(negedge clk);
        run_block(1, 0, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule